// File: doc/BRIEF.md
# Register File With Stallable Read Buffers

This block is the register storage of a core whose datapath is steered directly by the compiler. Every cycle it takes an 18-bit control field and one word of write data from the interconnect. It has two read ports and one write port. No pipeline controller sits between the field and the storage, so there is no forwarding, hazard checking or instruction decode here. The compiler settles all of that ahead of time and may leave out writes it knows to be redundant.

Each read port ends in a data register that serves as a pipeline register. A port reads a register in one cycle and shows the value after the next clock edge. Each port has its own stall bit, which freezes its data register for that cycle. Register 0 is hardwired to zero. A synchronous reset clears the storage and both data registers.

Top module: `regfile_stallbuf`

## Requirements
- R1: The control field is decoded from bit 0 upward as follows:
  - bits 4:0 are read address A;
  - bits 9:5 are read address B;
  - bits 14:10 are the write address;
  - bit 15 is write enable;
  - bit 16 is stall A;
  - bit 17 is stall B.
- R2: When stall A is 0 on a clock edge, `rd_a_q` takes the content of the register at read address A. The value is visible from that edge on.
- R3: When stall B is 0 on a clock edge, `rd_b_q` takes the content of the register at read address B. This is independent of port A.
- R4: When write enable is 1 on a clock edge, `wr_data` is stored at the write address. A read issued in any later cycle returns it.
- R5: When write enable is 0, no register changes, whatever the write address and write data are.
- R6: Register 0 always reads as zero. A write to register 0 has no effect.
- R7: When stall A is 1 on a clock edge, `rd_a_q` keeps its previous value.
- R8: When stall B is 1 on a clock edge, `rd_b_q` keeps its previous value.
- R9: If a read port and the write port name the same register in one cycle, the read data register captures the value held before that write.
- R10: While `rst` is 1 on a clock edge, every register and both read data registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_word | input | 18 | Per-cycle control field (layout in R1) |
| wr_data | input | 32 | Write data from the interconnect |
| rd_a_q | output | 32 | Read data register of port A |
| rd_b_q | output | 32 | Read data register of port B |

## Verification
Reads are tried in several ways:
- distinct values on distinct registers, so a swapped or misdecoded address field shows up;
- both ports on the same register;
- the two ports on crossed addresses, which separates A from B.

Writes are tried with the enable high and low at the same address, and against register 0. A same-cycle read and write of one register tells read-before-write apart from write-through. Stalling one port while the other reads a new register shows that each stall bit reaches only its own port. A reset after the file holds data shows that the storage itself is cleared, not only the outputs.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int RF_ADDR_W = 5;
   localparam int RF_DATA_W = 32;
   localparam int RF_NUM_RD = 2;

   // control field width: read addresses, write address, enable, one stall per port
   function automatic int rf_ctl_width(input int addr_w, input int num_rd);
      return (num_rd + 1) * addr_w + 1 + num_rd;
   endfunction

   typedef enum logic [0:0] {
      PORT_A = 1'b0,
      PORT_B = 1'b1
   } rf_port_e;
endpackage

// File: rtl/rf_ctl_decode.sv
module rf_ctl_decode
   import rf_pkg::*;
#(
   parameter int ADDR_W = RF_ADDR_W,
   parameter int NUM_RD = RF_NUM_RD,
   localparam int CTL_W = rf_ctl_width(ADDR_W, NUM_RD)
) (
   input  logic [CTL_W-1:0]               ctl,
   output logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
   output logic [ADDR_W-1:0]              wr_addr,
   output logic                           wr_en,
   output logic [NUM_RD-1:0]              stall
);
   localparam int WA_LSB    = NUM_RD * ADDR_W;
   localparam int WE_BIT    = WA_LSB + ADDR_W;
   localparam int STALL_LSB = WE_BIT + 1;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd_field
      assign rd_addr[p] = ctl[p*ADDR_W +: ADDR_W];
      assign stall[p]   = ctl[STALL_LSB + p];
   end

   assign wr_addr = ctl[WA_LSB +: ADDR_W];
   assign wr_en   = ctl[WE_BIT];
endmodule

// File: rtl/rf_storage.sv
module rf_storage
   import rf_pkg::*;
#(
   parameter int ADDR_W   = RF_ADDR_W,
   parameter int DATA_W   = RF_DATA_W,
   parameter int NUM_RD   = RF_NUM_RD,
   parameter bit ZERO_REG = 1'b1,
   localparam int DEPTH   = 1 << ADDR_W
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              wr_ok;

   if (ZERO_REG) begin : g_wr_guard
      assign wr_ok = wr_en && (wr_addr != '0);
   end else begin : g_wr_plain
      assign wr_ok = wr_en;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
         end
      end else if (wr_ok) begin
         mem[wr_addr] <= wr_data;
      end
   end

   // combinational reads see the contents before this edge's write
   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      if (ZERO_REG) begin : g_zero
         assign rd_data[p] = (rd_addr[p] == '0) ? '0 : mem[rd_addr[p]];
      end else begin : g_flat
         assign rd_data[p] = mem[rd_addr[p]];
      end
   end
endmodule

// File: rtl/rf_read_buf.sv
module rf_read_buf
   import rf_pkg::*;
#(
   parameter int DATA_W = RF_DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (!hold) begin
         q <= din;
      end
   end
endmodule

// File: rtl/regfile_stallbuf.sv
module regfile_stallbuf
   import rf_pkg::*;
#(
   parameter int ADDR_W   = RF_ADDR_W,
   parameter int DATA_W   = RF_DATA_W,
   parameter bit ZERO_REG = 1'b1,
   localparam int NUM_RD  = RF_NUM_RD,
   localparam int CTL_W   = rf_ctl_width(ADDR_W, NUM_RD)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CTL_W-1:0]  ctl_word,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_a_q,
   output logic [DATA_W-1:0] rd_b_q
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("regfile_stallbuf: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("regfile_stallbuf: DATA_W must be positive");
   end
   if (NUM_RD != 2) begin : g_bad_ports
      $error("regfile_stallbuf: exactly two read ports are supported");
   end

   logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_q;
   logic [ADDR_W-1:0]             wr_addr;
   logic                          wr_en;
   logic [NUM_RD-1:0]             stall;

   rf_ctl_decode #(.ADDR_W(ADDR_W), .NUM_RD(NUM_RD)) u_dec (
      .ctl     (ctl_word),
      .rd_addr (rd_addr),
      .wr_addr (wr_addr),
      .wr_en   (wr_en),
      .stall   (stall)
   );

   rf_storage #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_RD   (NUM_RD),
      .ZERO_REG (ZERO_REG)
   ) u_mem (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_buf
      rf_read_buf #(.DATA_W(DATA_W)) u_buf (
         .clk  (clk),
         .rst  (rst),
         .hold (stall[p]),
         .din  (rd_data[p]),
         .q    (rd_q[p])
      );
   end

   assign rd_a_q = rd_q[PORT_A];
   assign rd_b_q = rd_q[PORT_B];
endmodule

// File: rtl/rf_checker.sv
module rf_checker
   import rf_pkg::*;
#(
   parameter int ADDR_W   = RF_ADDR_W,
   parameter int DATA_W   = RF_DATA_W,
   parameter bit ZERO_REG = 1'b1,
   localparam int CTL_W   = rf_ctl_width(ADDR_W, RF_NUM_RD)
) (
   input logic              clk,
   input logic              rst,
   input logic [CTL_W-1:0]  ctl_word,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_a_q,
   input logic [DATA_W-1:0] rd_b_q
);
   logic [ADDR_W-1:0] c_ra, c_rb, c_wa;
   logic              c_we, c_sa, c_sb;

   assign c_ra = ctl_word[0 +: ADDR_W];
   assign c_rb = ctl_word[ADDR_W +: ADDR_W];
   assign c_wa = ctl_word[2*ADDR_W +: ADDR_W];
   assign c_we = ctl_word[3*ADDR_W];
   assign c_sa = ctl_word[3*ADDR_W + 1];
   assign c_sb = ctl_word[3*ADDR_W + 2];

   // R10: reset leaves both read data registers at zero
   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (rd_a_q == '0 && rd_b_q == '0));

   // R7: a stalled port A holds its data
   assert_hold_a_R7: assert property (@(posedge clk) disable iff (rst)
      c_sa |=> $stable(rd_a_q));

   // R8: a stalled port B holds its data
   assert_hold_b_R8: assert property (@(posedge clk) disable iff (rst)
      c_sb |=> $stable(rd_b_q));

   // R4: a write is seen by a port A read in the next cycle
   assert_write_seen_R4: assert property (@(posedge clk) disable iff (rst)
      (c_we && c_wa != '0) ##1 (!c_sa && c_ra == $past(c_wa))
      |=> rd_a_q == $past(wr_data, 2));

   if (ZERO_REG) begin : g_zero_chk
      // R6: register 0 reads as zero on either port
      assert_zero_a_R6: assert property (@(posedge clk) disable iff (rst)
         (!c_sa && c_ra == '0) |=> rd_a_q == '0);
      assert_zero_b_R6: assert property (@(posedge clk) disable iff (rst)
         (!c_sb && c_rb == '0) |=> rd_b_q == '0);
   end
endmodule

bind regfile_stallbuf rf_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .ZERO_REG (ZERO_REG)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ctl_word (ctl_word),
   .wr_data  (wr_data),
   .rd_a_q   (rd_a_q),
   .rd_b_q   (rd_b_q)
);

// File: tb/sim_regfile_stallbuf.sv
module sim_regfile_stallbuf;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [17:0] ctl_word = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_a_q, rd_b_q;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   regfile_stallbuf u0 (
      .clk      (clk),
      .rst      (rst),
      .ctl_word (ctl_word),
      .wr_data  (wr_data),
      .rd_a_q   (rd_a_q),
      .rd_b_q   (rd_b_q)
   );

   // R1 layout: {stall B, stall A, write enable, write addr, read B, read A}
   function automatic logic [17:0] mk(input logic [4:0] ra, input logic [4:0] rb,
                                      input logic [4:0] wa, input logic we,
                                      input logic sa, input logic sb);
      return {sb, sa, we, wa, rb, ra};
   endfunction

   // drive at the falling edge, sample 5 ns after the rising edge
   task automatic step(input logic r, input logic [17:0] c, input logic [31:0] d);
      @(negedge clk);
      rst = r;
      ctl_word = c;
      wr_data = d;
      @(posedge clk);
      #5;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic t_reset_state;
      step(1'b1, '0, '0);
      step(1'b1, '0, '0);
      check("R10 reset A", rd_a_q, 32'h0);
      check("R10 reset B", rd_b_q, 32'h0);
   endtask

   task automatic t_write_read;
      step(1'b0, mk(0, 0, 1, 1, 0, 0), 32'hA5A5_0001);
      step(1'b0, mk(0, 0, 2, 1, 0, 0), 32'h5A5A_0002);
      step(1'b0, mk(0, 0, 31, 1, 0, 0), 32'hDEAD_BEEF);
      step(1'b0, mk(1, 2, 0, 0, 0, 0), '0);
      check("R2 R4 R1 port A r1", rd_a_q, 32'hA5A5_0001);
      check("R3 R4 R1 port B r2", rd_b_q, 32'h5A5A_0002);
      step(1'b0, mk(31, 1, 0, 0, 0, 0), '0);
      check("R2 R1 port A r31", rd_a_q, 32'hDEAD_BEEF);
      check("R3 R1 port B r1", rd_b_q, 32'hA5A5_0001);
      step(1'b0, mk(2, 2, 0, 0, 0, 0), '0);
      check("R2 same reg A", rd_a_q, 32'h5A5A_0002);
      check("R3 same reg B", rd_b_q, 32'h5A5A_0002);
   endtask

   task automatic t_we_low;
      step(1'b0, mk(0, 0, 3, 1, 0, 0), 32'h0000_0111);
      step(1'b0, mk(0, 0, 3, 0, 0, 0), 32'h0000_0222);
      step(1'b0, mk(3, 3, 0, 0, 0, 0), '0);
      check("R5 no write A", rd_a_q, 32'h0000_0111);
      check("R5 no write B", rd_b_q, 32'h0000_0111);
   endtask

   task automatic t_zero_reg;
      step(1'b0, mk(0, 0, 0, 1, 0, 0), 32'hFFFF_FFFF);
      step(1'b0, mk(0, 0, 0, 0, 0, 0), '0);
      check("R6 zero A", rd_a_q, 32'h0);
      check("R6 zero B", rd_b_q, 32'h0);
   endtask

   task automatic t_stall;
      step(1'b0, mk(1, 2, 0, 0, 0, 0), '0);
      step(1'b0, mk(31, 31, 0, 0, 1, 0), '0);
      check("R7 A held", rd_a_q, 32'hA5A5_0001);
      check("R3 B moves while A stalled", rd_b_q, 32'hDEAD_BEEF);
      step(1'b0, mk(2, 1, 0, 0, 0, 1), '0);
      check("R2 A moves while B stalled", rd_a_q, 32'h5A5A_0002);
      check("R8 B held", rd_b_q, 32'hDEAD_BEEF);
   endtask

   task automatic t_collision;
      step(1'b0, mk(0, 0, 7, 1, 0, 0), 32'h0000_0AAA);
      step(1'b0, mk(7, 7, 7, 1, 0, 0), 32'h0000_0BBB);
      check("R9 old value A", rd_a_q, 32'h0000_0AAA);
      check("R9 old value B", rd_b_q, 32'h0000_0AAA);
      step(1'b0, mk(7, 0, 0, 0, 0, 0), '0);
      check("R4 new value after collision", rd_a_q, 32'h0000_0BBB);
   endtask

   task automatic t_reset_clears;
      step(1'b0, mk(1, 31, 0, 0, 0, 0), '0);
      step(1'b1, mk(1, 31, 0, 0, 0, 0), '0);
      check("R10 out A cleared", rd_a_q, 32'h0);
      check("R10 out B cleared", rd_b_q, 32'h0);
      step(1'b0, mk(1, 31, 0, 0, 0, 0), '0);
      check("R10 r1 cleared", rd_a_q, 32'h0);
      check("R10 r31 cleared", rd_b_q, 32'h0);
   endtask

   initial begin
      t_reset_state();
      t_write_read();
      t_we_low();
      t_zero_reg();
      t_stall();
      t_collision();
      t_reset_clears();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule